// File: doc/BRIEF.md
# I2C Slave Register-Bridge Window

This block is the byte-level back end of an I2C slave. It gives an external master a small byte-addressed window and bridges that window to an internal bus with 32-bit data. A front end handles SCL/SDA and signals start, restart and stop. It also signals each byte received, whether that byte is the first one after the slave address, and each request for a byte to send back. The block keeps a byte pointer that moves up by one after every data byte and keeps its value from one transaction to the next. It holds an address register and a data register for each direction.

Two byte offsets act as triggers. Fetching the low byte of the read-data window launches an internal bus read from the programmed read address. The front end is held off through `stall` until the bus acknowledges. The fetched word is then latched and sent back one byte at a time, least significant byte first. Storing the top byte of the write-data window sends the assembled word to the programmed write address. Host enables can block either direction. When a stop ends a transaction that completed a bus access, a sticky status bit is set. The host clears each status bit by writing a one to it, and `irq` reports every status bit whose enable is set.

Top module: `i2c_reg_bridge`

## Requirements
- R1: A received byte flagged `rx_first` loads the pointer with its value and changes no window register. A master can therefore set the pointer, issue a restart and read from that offset.
- R2: Start, restart and stop leave the pointer unchanged. A read that does not set the pointer continues from where the previous transaction stopped.
- R3: Every data byte, whether stored or fetched, goes to the current pointer, and the pointer then moves up by one (modulo 256).
- R4: Window layout, little-endian: 0x00–0x03 write address, 0x04–0x07 write data, 0x10–0x13 read address, 0x14–0x17 read data. Fetches from any other offset return 0x00, and stores to them have no effect. The read-data bytes cannot be written.
- R5: With `host_rd_en` high, fetching offset 0x14 issues one bus read (`bus_we`=0) at the read address. `stall` stays high until `bus_ack`. The returned word is latched, its byte 0 is delivered with `rd_valid`, and offsets 0x15–0x17 then deliver bytes 1–3.
- R6: With `host_wr_en` high, storing offset 0x07 issues one bus write (`bus_we`=1) at the write address. Its data is the byte just received over bits 31:24 and the stored bytes of 0x04–0x06 below it. `bus_req` and the bus fields stay stable until `bus_ack`.
- R7: With the matching enable low, the trigger offsets start no bus access. A fetch at 0x14 returns byte 0 of the last latched read word, and a store at 0x07 is dropped.
- R8: A stop or restart clears the write-data bytes. A store at 0x07 also clears them. A word that was not finished therefore never reaches the bus, and its lanes read as 0x00 afterwards.
- R9: At a stop, status bit 0 (read done) and bit 1 (write done) are set if a bus read or a bus write was acknowledged since the last start. A one on `host_clr` clears the matching bit, and a set in the same cycle wins. `irq` is high exactly when some status bit and its `host_irq_en` bit are both one.
- R10: After reset the pointer and all window registers are zero, and `status`, `irq`, `stall` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start condition pulse |
| ev_restart | input | 1 | Repeated-start pulse |
| ev_stop | input | 1 | Stop condition pulse |
| rx_valid | input | 1 | Byte received from master |
| rx_first | input | 1 | Received byte is the first after the slave address |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Front end asks for the next byte to send |
| rd_data | output | 8 | Byte to send |
| rd_valid | output | 1 | `rd_data` is ready (one-cycle pulse) |
| stall | output | 1 | Bus access in flight; front end stretches the clock |
| host_rd_en | input | 1 | Allow internal bus reads |
| host_wr_en | input | 1 | Allow internal bus writes |
| host_irq_en | input | 2 | Interrupt enables {write, read} |
| host_clr | input | 2 | Write-one-to-clear strobes for status |
| status | output | 2 | Sticky {write done, read done} |
| irq | output | 1 | Interrupt |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus write (1) or read (0) |
| bus_addr | output | BUS_AW | Internal bus address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Single-cycle completion |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
On every cycle the assertions check several invariants. The bus request and its fields stay stable until acknowledged, and a bus access starts only when its host enable was high. A pending read keeps the bus busy. A served fetch advances the pointer by one. A status bit rises only at a stop and falls only under a clear. The byte values themselves need the bench's scenarios: the pointer surviving across transactions, the little-endian lane placement, the zeroing of an unfinished write word, and the contents of the latched read word when the trigger is blocked.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int DW = 32;
  localparam int PW = 8;
  localparam logic [PW-1:0] OFS_WADDR  = 8'h00;
  localparam logic [PW-1:0] OFS_WDATA  = 8'h04;
  localparam logic [PW-1:0] OFS_COMMIT = 8'h07;
  localparam logic [PW-1:0] OFS_RADDR  = 8'h10;
  localparam logic [PW-1:0] OFS_FETCH  = 8'h14;
  localparam int ST_RD = 0;
  localparam int ST_WR = 1;

  function automatic logic in_win(logic [PW-1:0] p, logic [PW-1:0] base);
    return p[PW-1:2] == base[PW-1:2];
  endfunction

  function automatic logic [DW-1:0] put_lane(logic [DW-1:0] w, logic [1:0] l, logic [7:0] b);
    logic [DW-1:0] r;
    r = w;
    r[{l, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [7:0] get_lane(logic [DW-1:0] w, logic [1:0] l);
    return w[{l, 3'b000} +: 8];
  endfunction

  function automatic logic [7:0] win_byte(logic [PW-1:0] p, logic [DW-1:0] wa, logic [DW-1:0] wd,
                                          logic [DW-1:0] ra, logic [DW-1:0] rd);
    if (in_win(p, OFS_WADDR)) return get_lane(wa, p[1:0]);
    if (in_win(p, OFS_WDATA)) return get_lane(wd, p[1:0]);
    if (in_win(p, OFS_RADDR)) return get_lane(ra, p[1:0]);
    if (in_win(p, OFS_FETCH)) return get_lane(rd, p[1:0]);
    return 8'h00;
  endfunction
endpackage

// File: rtl/i2cb_window.sv
module i2cb_window
  import i2cb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_stop,
  input  logic          ev_restart,
  input  logic          rx_valid,
  input  logic          rx_first,
  input  logic [7:0]    rx_data,
  input  logic          rd_req,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] done_rdata,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          fire_rd,
  output logic          fire_wr,
  output logic [DW-1:0] waddr,
  output logic [DW-1:0] wword,
  output logic [DW-1:0] raddr
);
  logic [PW-1:0] ptr;
  logic [DW-1:0] wa, wd, ra, rdat;
  logic          rd_pend;
  logic          wr_byte, rd_serve;

  assign wr_byte  = rx_valid & ~rx_first & ~busy;
  assign fire_wr  = wr_byte & (ptr == OFS_COMMIT) & wr_en;
  assign fire_rd  = rd_req & ~busy & (ptr == OFS_FETCH) & rd_en;
  assign rd_serve = rd_req & ~busy & ~fire_rd;
  assign waddr    = wa;
  assign raddr    = ra;
  assign wword    = {rx_data, wd[23:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      wa       <= '0;
      wd       <= '0;
      ra       <= '0;
      rdat     <= '0;
      rd_pend  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (rx_valid && rx_first) begin
        ptr <= rx_data;
      end else if (wr_byte) begin
        ptr <= ptr + 8'd1;
        if (in_win(ptr, OFS_WADDR)) wa <= put_lane(wa, ptr[1:0], rx_data);
        if (in_win(ptr, OFS_WDATA))
          wd <= (ptr == OFS_COMMIT) ? '0 : put_lane(wd, ptr[1:0], rx_data);
        if (in_win(ptr, OFS_RADDR)) ra <= put_lane(ra, ptr[1:0], rx_data);
      end else if (fire_rd) begin
        ptr     <= ptr + 8'd1;
        rd_pend <= 1'b1;
      end else if (rd_serve) begin
        rd_data  <= win_byte(ptr, wa, wd, ra, rdat);
        rd_valid <= 1'b1;
        ptr      <= ptr + 8'd1;
      end
      if (done && rd_pend) begin
        rdat     <= done_rdata;
        rd_data  <= done_rdata[7:0];
        rd_valid <= 1'b1;
        rd_pend  <= 1'b0;
      end
      if (ev_stop || ev_restart) wd <= '0;
    end
  end

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_serve |=> ptr == $past(ptr) + 8'd1);

  // R5
  pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> busy);
endmodule

// File: rtl/i2cb_busctl.sv
module i2cb_busctl
  import i2cb_pkg::*;
#(
  parameter int BUS_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_rd,
  input  logic              fire_wr,
  input  logic [DW-1:0]     waddr,
  input  logic [DW-1:0]     wword,
  input  logic [DW-1:0]     raddr,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_we
);
  assign busy    = bus_req;
  assign done    = bus_req & bus_ack;
  assign done_we = bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (bus_req) begin
      if (bus_ack) bus_req <= 1'b0;
    end else if (fire_wr) begin
      bus_req   <= 1'b1;
      bus_we    <= 1'b1;
      bus_addr  <= waddr[BUS_AW-1:0];
      bus_wdata <= wword;
    end else if (fire_rd) begin
      bus_req   <= 1'b1;
      bus_we    <= 1'b0;
      bus_addr  <= raddr[BUS_AW-1:0];
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));
endmodule

// File: rtl/i2cb_status.sv
module i2cb_status
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       done,
  input  logic       done_we,
  input  logic [1:0] host_clr,
  input  logic [1:0] irq_en,
  output logic [1:0] status,
  output logic       irq
);
  logic [1:0] seen, hit;

  always_comb begin
    hit = '0;
    if (done) hit[done_we ? ST_WR : ST_RD] = 1'b1;
  end

  assign irq = |(status & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= '0;
      status <= '0;
    end else begin
      seen   <= (ev_start || ev_stop) ? 2'b00 : (seen | hit);
      status <= (status & ~host_clr) | (ev_stop ? (seen | hit) : 2'b00);
    end
  end

  // R9
  clr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_RD]) |-> $past(host_clr[ST_RD]));

  // R9
  clr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_WR]) |-> $past(host_clr[ST_WR]));

  // R9
  set_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[ST_RD]) || $rose(status[ST_WR])) |-> $past(ev_stop));
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge
  import i2cb_pkg::*;
#(
  parameter int BUS_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_restart,
  input  logic              ev_stop,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic [7:0]        rx_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              stall,
  input  logic              host_rd_en,
  input  logic              host_wr_en,
  input  logic [1:0]        host_irq_en,
  input  logic [1:0]        host_clr,
  output logic [1:0]        status,
  output logic              irq,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ack,
  input  logic [DW-1:0]     bus_rdata
);
  logic          fire_rd, fire_wr, busy, done, done_we;
  logic [DW-1:0] waddr, wword, raddr;

  assign stall = busy;

  i2cb_window u_window (
    .clk, .rst_n, .ev_stop, .ev_restart, .rx_valid, .rx_first, .rx_data, .rd_req,
    .rd_en(host_rd_en), .wr_en(host_wr_en), .busy, .done, .done_rdata(bus_rdata),
    .rd_data, .rd_valid, .fire_rd, .fire_wr, .waddr, .wword, .raddr
  );

  i2cb_busctl #(.BUS_AW(BUS_AW)) u_busctl (
    .clk, .rst_n, .fire_rd, .fire_wr, .waddr, .wword, .raddr, .bus_ack,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .busy, .done, .done_we
  );

  i2cb_status u_status (
    .clk, .rst_n, .ev_start, .ev_stop, .done, .done_we, .host_clr,
    .irq_en(host_irq_en), .status, .irq
  );

  // R7
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && bus_we) |-> $past(host_wr_en));

  // R7
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && !bus_we) |-> $past(host_rd_en));
endmodule

// File: tb/test_i2c_reg_bridge.sv
`timescale 1ns/100ps
module test_i2c_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 0, ev_restart = 0, ev_stop = 0;
  logic        rx_valid = 0, rx_first = 0, rd_req = 0;
  logic [7:0]  rx_data = 0;
  logic        host_rd_en = 0, host_wr_en = 0;
  logic [1:0]  host_irq_en = 0, host_clr = 0;
  logic [7:0]  rd_data;
  logic        rd_valid, stall, irq, bus_req, bus_we, bus_ack;
  logic [1:0]  status;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, lat = 2;
  logic [31:0] last_addr, last_wdata;

  always #2.5 clk = ~clk;

  i2c_reg_bridge i_i2c_reg_bridge (.*);

  function automatic logic [31:0] model(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (lat == 0) begin
          bus_ack <= 1'b1;
          bus_rdata <= model(bus_addr);
          if (bus_we) begin wr_cnt <= wr_cnt + 1; last_addr <= bus_addr; last_wdata <= bus_wdata; end
          else rd_cnt <= rd_cnt + 1;
          lat <= $urandom_range(0, 5);
        end else lat <= lat - 1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start();   @(negedge clk); ev_start = 1;   @(negedge clk); ev_start = 0;   endtask
  task automatic pulse_restart(); @(negedge clk); ev_restart = 1; @(negedge clk); ev_restart = 0; endtask
  task automatic pulse_stop();
    @(negedge clk); while (stall) @(negedge clk);
    ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask
  task automatic clear(logic [1:0] v); @(negedge clk); host_clr = v; @(negedge clk); host_clr = 0; endtask

  task automatic wbyte(logic [7:0] b, logic f);
    @(negedge clk); while (stall) @(negedge clk);
    rx_valid = 1; rx_first = f; rx_data = b;
    @(negedge clk); rx_valid = 0; rx_first = 0;
  endtask

  task automatic rbyte(output logic [7:0] b);
    @(negedge clk); while (stall) @(negedge clk);
    rd_req = 1;
    @(negedge clk); rd_req = 0;
    while (!rd_valid) @(negedge clk);
    b = rd_data;
  endtask

  task automatic set_word(logic [7:0] ofs, logic [31:0] w);
    wbyte(ofs, 1);
    for (int i = 0; i < 4; i++) wbyte(w[i*8 +: 8], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] wa, wd, ra, m;
    int n0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 status", {30'd0, status}, 0);
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 bus_req", {31'd0, bus_req}, 0);
    chk("R10 stall", {31'd0, stall}, 0);
    pulse_start(); rbyte(b); pulse_stop();
    chk("R10 ptr 0 reads zero waddr", {24'd0, b}, 0);

    // R1 set read address, then point with first byte only
    pulse_start(); set_word(8'h10, 32'h44332211); pulse_stop();
    pulse_start(); wbyte(8'h12, 1); pulse_stop();
    pulse_start(); rbyte(b);
    chk("R2 ptr kept across stop", {24'd0, b}, 32'h33);
    rbyte(b);
    chk("R3 increment", {24'd0, b}, 32'h44);
    n0 = rd_cnt;
    rbyte(b);
    chk("R7 blocked fetch returns latched byte0", {24'd0, b}, 0);
    chk("R7 no bus read when blocked", rd_cnt, n0);
    pulse_stop();
    chk("R7 no read status", {30'd0, status}, 0);
    pulse_start(); wbyte(8'h10, 1); pulse_restart(); rbyte(b);
    chk("R1 pointer then restart read", {24'd0, b}, 32'h11);
    pulse_stop();

    // R4 unmapped offsets
    pulse_start(); wbyte(8'h20, 1); wbyte(8'hAB, 0); pulse_restart(); wbyte(8'h20, 1);
    pulse_restart(); rbyte(b); pulse_stop();
    chk("R4 unmapped store ignored", {24'd0, b}, 0);
    pulse_start(); wbyte(8'h0B, 1); pulse_restart(); rbyte(b); pulse_stop();
    chk("R4 unmapped fetch zero", {24'd0, b}, 0);

    // R6 bus write
    host_wr_en = 1;
    pulse_start(); set_word(8'h00, 32'hCAFE0010); for (int i = 0; i < 4; i++) wbyte(8'h10 + 8'(i), 0);
    pulse_stop();
    chk("R6 write count", wr_cnt, 1);
    chk("R6 write addr", last_addr, 32'hCAFE0010);
    chk("R6 write data", last_wdata, 32'h13121110);
    chk("R9 write status", {30'd0, status}, 2);
    chk("R9 irq masked", {31'd0, irq}, 0);
    host_irq_en = 2'b10; @(negedge clk);
    chk("R9 irq enabled", {31'd0, irq}, 1);
    clear(2'b10);
    chk("R9 w1c", {30'd0, status}, 0);
    chk("R9 irq after clear", {31'd0, irq}, 0);

    // R7 write blocked
    host_wr_en = 0;
    pulse_start(); wbyte(8'h04, 1); for (int i = 0; i < 4; i++) wbyte(8'h55, 0); pulse_stop();
    chk("R7 no bus write", wr_cnt, 1);
    chk("R7 no write status", {30'd0, status}, 0);

    // R8 partial word discarded
    host_wr_en = 1;
    pulse_start(); wbyte(8'h04, 1); wbyte(8'hAA, 0); wbyte(8'hBB, 0); pulse_stop();
    pulse_start(); wbyte(8'h04, 1); pulse_restart(); rbyte(b);
    chk("R8 lane0 cleared at stop", {24'd0, b}, 0);
    rbyte(b);
    chk("R8 lane1 cleared at stop", {24'd0, b}, 0);
    pulse_stop();
    pulse_start(); wbyte(8'h04, 1); wbyte(8'h11, 0); pulse_restart(); wbyte(8'h07, 1); wbyte(8'h22, 0);
    pulse_stop();
    chk("R8 restart drops partial word", last_wdata, 32'h22000000);
    clear(2'b11);

    // R5 bus read with stall
    host_rd_en = 1;
    pulse_start(); set_word(8'h10, 32'h00C0FFEE); pulse_restart();
    @(negedge clk); rd_req = 1; @(negedge clk); rd_req = 0;
    chk("R5 stall during fetch", {31'd0, stall}, 1);
    while (!rd_valid) @(negedge clk);
    m = model(32'h00C0FFEE);
    chk("R5 byte0", {24'd0, rd_data}, {24'd0, m[7:0]});
    for (int i = 1; i < 4; i++) begin rbyte(b); chk("R5 byte", {24'd0, b}, {24'd0, m[i*8 +: 8]}); end
    pulse_stop();
    chk("R9 read status", {30'd0, status}, 1);
    clear(2'b01);

    // random traffic
    for (int it = 0; it < 25; it++) begin
      wa = $urandom; wd = $urandom; ra = $urandom;
      n0 = wr_cnt;
      pulse_start(); set_word(8'h00, wa); for (int i = 0; i < 4; i++) wbyte(wd[i*8 +: 8], 0);
      pulse_stop();
      chk("R6 rand count", wr_cnt, n0 + 1);
      chk("R6 rand addr", last_addr, wa);
      chk("R6 rand data", last_wdata, wd);
      chk("R9 rand wr status", {30'd0, status}, 2);
      pulse_start(); set_word(8'h10, ra); pulse_restart();
      m = model(ra);
      for (int i = 0; i < 4; i++) begin rbyte(b); chk("R5 rand byte", {24'd0, b}, {24'd0, m[i*8 +: 8]}); end
      pulse_stop();
      chk("R9 rand both status", {30'd0, status}, 3);
      clear(2'b11);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule